// File: doc/BRIEF.md
# Three-Tap Vertical Field Interlacer

This block turns a progressive pixel stream into a stream of interlaced fields. Each input frame becomes one output field. Consecutive frames alternate between the two field parities. Every output line is a vertical blend of three neighbouring input lines, weighted one quarter, one half and one quarter. The blend damps the flicker that a thin horizontal detail would otherwise cause at the field rate. Two line memories hold the two most recent input lines. The weighted sum needs only shifts and adds, and each colour component is filtered separately.

The two field parities take their line triples one line apart, so the fields sit one line apart vertically. When a tap falls outside the frame it reads as zero: the top tap of the first line of the top field, and the bottom tap of the last line of the bottom field. The bottom field's last line has no input line after it. The block therefore replays it from its line memories during the blanking that follows the frame. Both line memories count as empty at the start of every frame.

The block emits one output line for every two input lines, at input pixel rate. Downstream timing logic is expected to pace it to half the line rate.

Top module: `field_interlacer`

## Requirements
- R1: While `rst` is high, and in the cycle after it falls, `out_valid`, `out_sof` and `out_eol` are low.
- R2: For each component k (bits [8k+7:8k] with the default 8-bit components), the output is floor((top + 2·mid + bottom) / 4). The sum has no overflow: all-maximum inputs give all-maximum outputs.
- R3: `out_field` is 0 for the field started by the first input start-of-frame after reset. It toggles at each later input start-of-frame and stays constant across all pixels of a field.
- R4: Field 0 emits output line n while input line 2n arrives (input lines are numbered from 1). It blends lines 2n-2, 2n-1 and 2n, and line 0 reads as zero. Odd input lines produce no output.
- R5: Field 1 emits output line n while input line 2n+1 arrives, blending lines 2n-1, 2n and 2n+1. Input line 1 produces no output. When FRAME_LINES is even, the last output line blends lines FRAME_LINES-1 and FRAME_LINES with a zero bottom tap. It is replayed at one pixel per cycle, with pixel j appearing 3+j cycles after the frame's last input pixel. The input must stay idle for the line length plus 3 cycles.
- R6: Both line memories count as empty from each input start-of-frame on. No pixel of an earlier frame reaches the output.
- R7: Each pixel-driven output appears exactly 2 cycles after the input pixel that completes it, and gaps in the input valid carry through unchanged. `out_eol` marks the last pixel of each output line, and there is no other output.
- R8: `out_sof` is high on the first output pixel of each field and on no other.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Input pixel present this cycle |
| in_sof | input | 1 | First pixel of a frame |
| in_eol | input | 1 | Last pixel of an input line |
| in_data | input | COMP_W*NUM_COMP | Input pixel, component k at bits [k*COMP_W +: COMP_W] |
| out_valid | output | 1 | Output pixel present |
| out_sof | output | 1 | First pixel of an output field |
| out_eol | output | 1 | Last pixel of an output line |
| out_field | output | 1 | Field parity of the output pixel |
| out_data | output | COMP_W*NUM_COMP | Filtered pixel |

## Verification
Two pairs of actions can land in the same cycle. The first pair is the bottom field's replay, whose first read of column 0 falls in the same cycle as the delayed write of the last column into the second line memory. The second pair is a new start-of-frame that arrives the cycle after a line end, so the clearing of the fill flags meets the flags being set by that line end. The bench provokes the second pair by starting a bottom field directly after a top field with no idle cycle. It provokes the first pair by ending every bottom field on an even line count. The behavioural model predicts every output cycle, including the replayed line, and compares on every clock. A wrong order of these actions shows up as a displaced or stale line.

// File: rtl/fi_pkg.sv
package fi_pkg;
  // per-pixel control word handed from the sequencer to the datapath
  typedef struct packed {
    logic emit;      // this beat produces an output pixel
    logic sof;       // first output pixel of the field
    logic eol;       // last output pixel of the line
    logic fld;       // field parity
    logic zero_bot;  // bottom tap forced to zero (replayed line)
    logic v1;        // first line memory holds a full line
    logic v2;        // second line memory holds a full line
  } fi_ctl_t;
endpackage

// File: rtl/fi_line_mem.sv
module fi_line_mem #(
  parameter int DW    = 24,
  parameter int DEPTH = 16,
  localparam int AW   = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [DW-1:0] wdata,
  input  logic [AW-1:0] raddr,
  output logic [DW-1:0] rdata
);
  logic [DW-1:0] mem [DEPTH];

  // simple dual port, registered read, read-before-write
  always_ff @(posedge clk) begin
    rdata <= mem[raddr];
    if (we) mem[waddr] <= wdata;
  end
endmodule

// File: rtl/fi_seq.sv
module fi_seq import fi_pkg::*; #(
  parameter int MAX_PIX     = 16,
  parameter int FRAME_LINES = 6,
  localparam int AW = $clog2(MAX_PIX),
  localparam int LW = $clog2(FRAME_LINES + 2)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          in_valid,
  input  logic          in_sof,
  input  logic          in_eol,
  output logic [AW-1:0] rd_addr,
  output logic [AW-1:0] wr_addr,
  output logic          wr2_req,
  output fi_ctl_t       ctl
);
  localparam logic [LW-1:0] LAST_LINE  = LW'(FRAME_LINES);
  localparam logic [LW-1:0] LINE_CAP   = LW'(FRAME_LINES + 1);
  localparam bit            EVEN_FRAME = (FRAME_LINES % 2) == 0;

  logic          field_q, v1_q, v2_q, first_q;
  logic [LW-1:0] line_q;
  logic [AW-1:0] col_q;
  logic          flush_on;
  logic [AW-1:0] flush_col, flush_last;

  logic          cur_field, cur_v1, cur_v2, pick, emit_pix, last_b, first_now;
  logic [LW-1:0] cur_line;
  logic [AW-1:0] cur_col;

  always_comb begin
    cur_line  = (in_valid && in_sof) ? LW'(1) : line_q;
    cur_col   = (in_valid && in_sof) ? '0 : col_q;
    cur_field = (in_valid && in_sof) ? ~field_q : field_q;
    cur_v1    = (in_valid && in_sof) ? 1'b0 : v1_q;
    cur_v2    = (in_valid && in_sof) ? 1'b0 : v2_q;
    if (!cur_field) pick = !cur_line[0] && (cur_line >= LW'(2));
    else            pick =  cur_line[0] && (cur_line >= LW'(3));
    emit_pix  = in_valid && pick;
    last_b    = in_valid && in_eol && cur_field && (cur_line == LAST_LINE) && EVEN_FRAME;
    first_now = (in_valid && in_sof) || first_q;

    rd_addr = flush_on ? flush_col : cur_col;
    wr_addr = cur_col;
    wr2_req = in_valid && cur_v1;

    ctl.emit     = emit_pix || flush_on;
    ctl.sof      = (emit_pix || flush_on) && first_now;
    ctl.eol      = flush_on ? (flush_col == flush_last) : in_eol;
    ctl.fld      = flush_on ? field_q : cur_field;
    ctl.zero_bot = flush_on;
    ctl.v1       = flush_on ? v1_q : cur_v1;
    ctl.v2       = flush_on ? v2_q : cur_v2;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      field_q    <= 1'b1;
      line_q     <= '0;
      col_q      <= '0;
      v1_q       <= 1'b0;
      v2_q       <= 1'b0;
      first_q    <= 1'b0;
      flush_on   <= 1'b0;
      flush_col  <= '0;
      flush_last <= '0;
    end else begin
      if (in_valid) begin
        field_q <= cur_field;
        if (in_eol) begin
          col_q  <= '0;
          line_q <= (cur_line == LINE_CAP) ? LINE_CAP : cur_line + LW'(1);
          v1_q   <= 1'b1;
          v2_q   <= cur_v1;
        end else begin
          col_q  <= cur_col + AW'(1);
          line_q <= cur_line;
          v1_q   <= cur_v1;
          v2_q   <= cur_v2;
        end
      end
      if (in_valid && in_sof)  first_q <= 1'b1;
      else if (ctl.emit)       first_q <= 1'b0;
      if (last_b) begin
        flush_on   <= 1'b1;
        flush_col  <= '0;
        flush_last <= cur_col;
      end else if (flush_on) begin
        flush_col <= flush_col + AW'(1);
        if (flush_col == flush_last) flush_on <= 1'b0;
      end
    end
  end

  // the middle tap always comes from a filled line memory
  assert_mid_tap_filled_R4: assert property (@(posedge clk) disable iff (rst)
    ctl.emit |-> ctl.v1);
  // input stays idle while the last bottom-field line is replayed
  assert_idle_during_replay_R5: assert property (@(posedge clk) disable iff (rst)
    flush_on |-> !in_valid);
  // every input frame start flips the parity
  assert_parity_flip_R3: assert property (@(posedge clk) disable iff (rst)
    (in_valid && in_sof) |=> (field_q != $past(field_q)));
  // a new frame starts with both line memories empty
  assert_mem_cleared_R6: assert property (@(posedge clk) disable iff (rst)
    (in_valid && in_sof && !in_eol) |=> (!v1_q && !v2_q));
endmodule

// File: rtl/fi_tap_sum.sv
module fi_tap_sum #(
  parameter int CW = 8,
  parameter int NC = 3,
  localparam int PW = CW * NC
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          emit,
  input  logic          sof,
  input  logic          eol,
  input  logic          fld,
  input  logic [PW-1:0] top_i,
  input  logic [PW-1:0] mid_i,
  input  logic [PW-1:0] bot_i,
  output logic          out_valid,
  output logic          out_sof,
  output logic          out_eol,
  output logic          out_field,
  output logic [PW-1:0] out_data
);
  logic [PW-1:0] avg;

  for (genvar k = 0; k < NC; k++) begin : g_comp
    logic [CW+1:0] s;
    assign s = {2'b00, top_i[k*CW +: CW]}
             + {1'b0, mid_i[k*CW +: CW], 1'b0}
             + {2'b00, bot_i[k*CW +: CW]};
    assign avg[k*CW +: CW] = CW'(s >> 2);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid <= 1'b0;
      out_sof   <= 1'b0;
      out_eol   <= 1'b0;
      out_field <= 1'b0;
      out_data  <= '0;
    end else begin
      out_valid <= emit;
      out_sof   <= emit && sof;
      out_eol   <= emit && eol;
      if (emit) begin
        out_field <= fld;
        out_data  <= avg;
      end
    end
  end
endmodule

// File: rtl/field_interlacer.sv
module field_interlacer import fi_pkg::*; #(
  parameter int COMP_W      = 8,
  parameter int NUM_COMP    = 3,
  parameter int MAX_PIX     = 16,
  parameter int FRAME_LINES = 6,
  localparam int PW = COMP_W * NUM_COMP,
  localparam int AW = $clog2(MAX_PIX)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          in_valid,
  input  logic          in_sof,
  input  logic          in_eol,
  input  logic [PW-1:0] in_data,
  output logic          out_valid,
  output logic          out_sof,
  output logic          out_eol,
  output logic          out_field,
  output logic [PW-1:0] out_data
);
  fi_ctl_t       a_ctl, b_ctl;
  logic [AW-1:0] rd_addr, wr_addr, b_col;
  logic          wr2_req, b_wr2;
  logic [PW-1:0] b_pix, m1_rd, m2_rd, top_t, mid_t, bot_t;

  fi_seq #(.MAX_PIX(MAX_PIX), .FRAME_LINES(FRAME_LINES)) u_seq (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_sof(in_sof), .in_eol(in_eol),
    .rd_addr(rd_addr), .wr_addr(wr_addr), .wr2_req(wr2_req), .ctl(a_ctl)
  );

  // first line delay: written with the incoming pixel
  fi_line_mem #(.DW(PW), .DEPTH(MAX_PIX)) u_mem1 (
    .clk(clk), .we(in_valid), .waddr(wr_addr), .wdata(in_data),
    .raddr(rd_addr), .rdata(m1_rd)
  );

  // second line delay: fed from the first one a cycle later
  fi_line_mem #(.DW(PW), .DEPTH(MAX_PIX)) u_mem2 (
    .clk(clk), .we(b_wr2), .waddr(b_col), .wdata(m1_rd),
    .raddr(rd_addr), .rdata(m2_rd)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      b_ctl <= '0;
      b_wr2 <= 1'b0;
    end else begin
      b_ctl <= a_ctl;
      b_wr2 <= wr2_req;
    end
  end

  always_ff @(posedge clk) begin
    b_col <= wr_addr;
    b_pix <= in_data;
  end

  assign top_t = b_ctl.v2 ? m2_rd : '0;
  assign mid_t = b_ctl.v1 ? m1_rd : '0;
  assign bot_t = b_ctl.zero_bot ? '0 : b_pix;

  fi_tap_sum #(.CW(COMP_W), .NC(NUM_COMP)) u_sum (
    .clk(clk), .rst(rst), .emit(b_ctl.emit), .sof(b_ctl.sof), .eol(b_ctl.eol),
    .fld(b_ctl.fld), .top_i(top_t), .mid_i(mid_t), .bot_i(bot_t),
    .out_valid(out_valid), .out_sof(out_sof), .out_eol(out_eol),
    .out_field(out_field), .out_data(out_data)
  );

  assert_reset_quiet_R1: assert property (@(posedge clk)
    rst |=> !out_valid);
  assert_sof_has_valid_R8: assert property (@(posedge clk) disable iff (rst)
    out_sof |-> out_valid);
  assert_eol_has_valid_R7: assert property (@(posedge clk) disable iff (rst)
    out_eol |-> out_valid);
  assert_field_steady_R3: assert property (@(posedge clk) disable iff (rst)
    (out_valid && !out_sof && $past(out_valid)) |-> $stable(out_field));
endmodule

// File: tb/field_interlacer_tb.sv
module field_interlacer_tb;
  localparam int CW = 8, NC = 3, MP = 16, FL = 6;
  localparam int PW = CW * NC;
  localparam int NCYC = 4096;

  logic clk = 1'b0;
  logic rst, in_valid, in_sof, in_eol;
  logic [PW-1:0] in_data;
  logic out_valid, out_sof, out_eol, out_field;
  logic [PW-1:0] out_data;

  always #4 clk = ~clk;  // 125 MHz

  field_interlacer #(.COMP_W(CW), .NUM_COMP(NC), .MAX_PIX(MP), .FRAME_LINES(FL)) u_dut (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_sof(in_sof), .in_eol(in_eol),
    .in_data(in_data), .out_valid(out_valid), .out_sof(out_sof), .out_eol(out_eol),
    .out_field(out_field), .out_data(out_data)
  );

  int checks = 0, errors = 0, cyc = 0;
  bit done = 0;

  // expected output per cycle
  bit          ev [NCYC];
  bit          es [NCYC];
  bit          ee [NCYC];
  bit          ef [NCYC];
  logic [PW-1:0] ed [NCYC];
  string       et [NCYC];

  // behavioural model state
  logic [PW-1:0] img [FL+2][MP];
  int mfield = 1, mline = 0, mcol = 0;
  bit mfirst = 0;
  string dtag = "R7";

  function automatic logic [PW-1:0] f3(input logic [PW-1:0] a, input logic [PW-1:0] b,
                                       input logic [PW-1:0] c);
    logic [PW-1:0] r;
    for (int i = 0; i < NC; i++) begin
      int s;
      s = int'(a[i*CW +: CW]) + 2 * int'(b[i*CW +: CW]) + int'(c[i*CW +: CW]);
      r[i*CW +: CW] = CW'(s / 4);
    end
    return r;
  endfunction

  function automatic logic [PW-1:0] pix(input int fr, input int l, input int c, input int mode);
    logic [31:0] h;
    case (mode)
      0: return {8'(l * 30 + c), 8'(c * 15), 8'(fr * 50 + l)};
      1: begin
        h = 32'(fr * 7919 + l * 613 + c * 97 + 11) * 32'h9E3779B1;
        return h[31:8];
      end
      2: return '1;
      default: return (l == 4) ? '1 : '0;
    endcase
  endfunction

  task automatic put_exp(input int t, input logic [PW-1:0] d, input bit s, input bit e,
                         input bit f);
    ev[t] = 1; ed[t] = d; es[t] = s; ee[t] = e; ef[t] = f; et[t] = dtag;
  endtask

  task automatic fail(input string req, input string what, input logic [PW-1:0] got,
                      input logic [PW-1:0] exp);
    errors++;
    $display("FAIL %s %s cycle %0d got %h exp %h", req, what, cyc, got, exp);
  endtask

  task automatic check_out();
    checks++;
    if (out_valid !== ev[cyc]) fail("R7", "out_valid", PW'(out_valid), PW'(ev[cyc]));
    else if (ev[cyc]) begin
      checks += 4;
      if (out_data !== ed[cyc]) fail(et[cyc], "out_data", out_data, ed[cyc]);
      if (out_sof !== es[cyc]) fail("R8", "out_sof", PW'(out_sof), PW'(es[cyc]));
      if (out_eol !== ee[cyc]) fail("R7", "out_eol", PW'(out_eol), PW'(ee[cyc]));
      if (out_field !== ef[cyc]) fail("R3", "out_field", PW'(out_field), PW'(ef[cyc]));
    end
  endtask

  task automatic tick();
    @(negedge clk);
    cyc++;
    if (!done) check_out();
  endtask

  task automatic idle(input int n);
    in_valid = 0; in_sof = 0; in_eol = 0;
    repeat (n) tick();
  endtask

  // drive one pixel and predict its outputs
  task automatic send(input logic [PW-1:0] d, input bit sof, input bit eol);
    logic [PW-1:0] top;
    in_valid = 1; in_sof = sof; in_eol = eol; in_data = d;
    if (sof) begin mfield ^= 1; mline = 1; mcol = 0; mfirst = 1; end
    img[mline][mcol] = d;
    if (mfield == 0 && mline % 2 == 0 && mline >= 2) begin        // R4
      top = (mline - 2 >= 1) ? img[mline-2][mcol] : '0;
      put_exp(cyc + 2, f3(top, img[mline-1][mcol], d), mfirst, eol, 0);
      mfirst = 0;
    end else if (mfield == 1 && mline % 2 == 1 && mline >= 3) begin // R5
      put_exp(cyc + 2, f3(img[mline-2][mcol], img[mline-1][mcol], d), mfirst, eol, 1);
      mfirst = 0;
    end
    if (eol) begin
      if (mfield == 1 && mline == FL && FL % 2 == 0)
        for (int j = 0; j <= mcol; j++)                             // R5 replay
          put_exp(cyc + 3 + j, f3(img[FL-1][j], img[FL][j], '0), 0, j == mcol, 1);
      mline++; mcol = 0;
    end else mcol++;
    tick();
  endtask

  task automatic send_frame(input int fr, input int width, input int mode, input bit gaps,
                            input string tag);
    dtag = tag;
    for (int l = 1; l <= FL; l++)
      for (int c = 0; c < width; c++) begin
        if (gaps && (c % 3 == 2)) idle(1);
        send(pix(fr, l, c, mode), l == 1 && c == 0, c == width - 1);
      end
  endtask

  initial begin
    #(8 * 200000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      done = 1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    rst = 1; in_valid = 0; in_sof = 0; in_eol = 0; in_data = '0;
    for (int k = 0; k < 4; k++) begin
      tick();
      checks++;  // R1: quiet while in reset
      if (out_valid || out_sof || out_eol) fail("R1", "reset outputs", PW'(out_valid), '0);
    end
    rst = 0;
    tick();
    checks++;  // R1: quiet in the cycle after reset
    if (out_valid || out_sof || out_eol) fail("R1", "post-reset outputs", PW'(out_valid), '0);
    idle(3);

    send_frame(1, 5, 0, 0, "R4");    // field 0, ramp
    send_frame(2, 8, 1, 0, "R5");    // field 1 back to back with field 0
    idle(20);
    send_frame(3, 16, 2, 0, "R2");   // all-maximum, field 0
    idle(2);
    send_frame(4, 16, 2, 0, "R2");   // all-maximum, field 1 with replay
    idle(24);
    send_frame(5, 16, 1, 0, "R6");   // field 0 after bright frame: top tap must be zero
    idle(2);
    send_frame(6, 16, 3, 0, "R5");   // single bright line, field 1
    idle(24);
    send_frame(7, 12, 1, 1, "R7");   // valid gaps, field 0
    idle(2);
    send_frame(8, 12, 1, 1, "R5");   // valid gaps, field 1
    idle(24);

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule